// File: doc/BRIEF.md
# Adaptive Stratum Size Predictor

A multiprocessor that runs threads in lock-step epochs ("strata") has to pick how many instructions each epoch may run before every core stops and publishes its buffered stores. Long epochs even out differences in instruction mix between cores. Short epochs waste less time when threads synchronize often or when the store buffer fills up. This block picks the instruction budget for the next epoch. It looks only at why the previous epoch closed.

Each time an epoch closes, the block receives a one-cycle end strobe and three cause flags: barrier or synchronization, write-buffer overflow, and budget reached. An epoch that closed early, because of synchronization or overflow, moves a small confidence counter down. Any other close moves the counter up. When the counter reaches either rail, the budget halves or doubles and the counter reloads its rest value. The budget is always a power of two and is clamped between parameterised limits. The controller that counts instructions against this budget sits outside the block.

Top module: `stratum_size_predictor`

## Requirements
- R1: While reset is high, and on the first cycle after it, the size output equals 2**INIT_LOG2 (256 with default parameters), and the confidence counter holds its rest value of 1.
- R2: In a cycle where end_pulse is low, the size does not change, whatever the cause flags show.
- R3: An end strobe with sync_end or ovf_end high counts as an early end and lowers the counter by one. When the counter is at its rest value, a single early end halves the size on the clock edge that samples the strobe.
- R4: An end strobe with neither sync_end nor ovf_end high raises the counter by one, whether thr_end is high or low. Starting from rest, two such ends double the size, and the new size appears on the edge that samples the second strobe.
- R5: When an early-cause flag and thr_end are both high on the same strobe, the early cause wins and the counter is lowered.
- R6: After any resize event the counter reloads its rest value. An up step followed by a down step therefore leaves the size unchanged.
- R7: At 2**MAX_LOG2 a grow event leaves the size unchanged, but the counter still reloads. The next early end then halves the size at once.
- R8: At 2**MIN_LOG2 a shrink event leaves the size unchanged, but the counter still reloads. Two later up steps then double the size.
- R9: The size is always exactly one set bit, lies between 2**MIN_LOG2 and 2**MAX_LOG2, and changes by at most a factor of two per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| end_pulse | input | 1 | One-cycle strobe marking the close of an epoch |
| sync_end | input | 1 | The epoch closed on a barrier or synchronization |
| ovf_end | input | 1 | The epoch closed because the write buffer overflowed |
| thr_end | input | 1 | The epoch closed because its instruction budget ran out |
| size_o | output | SIZE_W | Instruction budget for the next epoch (power of two) |

## Verification
The assertions assume that every cycle in which end_pulse is high is a separate epoch close, and that the cause flags carry meaning only in such a cycle. They also assume that reset is held for at least one clock edge before the first strobe. The bench holds reset high from time zero for several edges. It drives each strobe as a single cycle from the falling edge and returns all inputs to zero between vectors. It also sets cause flags with end_pulse low, to check that those flags have no effect.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        RESIZE_NONE   = 2'd0,
        RESIZE_GROW   = 2'd1,
        RESIZE_SHRINK = 2'd2
    } resize_e;

    typedef struct packed {
        logic fire;   // epoch closed this cycle
        logic early;  // closed on synchronization or overflow
        logic late;   // closed on budget or for no stated reason
    } end_cause_t;

    function automatic step_e classify(end_cause_t c);
        if (!c.fire)      return STEP_HOLD;
        else if (c.early) return STEP_DOWN;
        else if (c.late)  return STEP_UP;
        else              return STEP_HOLD;
    endfunction

endpackage

// File: rtl/stp_cause_decode.sv
module stp_cause_decode
    import stp_pkg::*;
(
    input  logic  end_pulse,
    input  logic  sync_end,
    input  logic  ovf_end,
    input  logic  thr_end,
    output step_e step
);
    end_cause_t cause;

    always_comb begin
        cause.fire  = end_pulse;
        cause.early = sync_end | ovf_end;
        cause.late  = thr_end | ~(sync_end | ovf_end);
        step        = classify(cause);
    end
endmodule

// File: rtl/stp_conf_ctr.sv
module stp_conf_ctr
    import stp_pkg::*;
#(
    parameter int CONF_W = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  step_e   step,
    output resize_e resize
);
    localparam logic [CONF_W-1:0] TOP = CONF_W'((1 << CONF_W) - 1);
    localparam logic [CONF_W-1:0] MID = CONF_W'((1 << (CONF_W - 1)) - 1);
    localparam logic [CONF_W-1:0] ONE = CONF_W'(1);

    logic [CONF_W-1:0] ctr_q, ctr_d;

    always_comb begin
        ctr_d  = ctr_q;
        resize = RESIZE_NONE;
        unique case (step)
            STEP_UP: begin
                if (ctr_q == TOP - ONE) begin
                    resize = RESIZE_GROW;
                    ctr_d  = MID;
                end else begin
                    ctr_d = ctr_q + ONE;
                end
            end
            STEP_DOWN: begin
                if (ctr_q == ONE) begin
                    resize = RESIZE_SHRINK;
                    ctr_d  = MID;
                end else begin
                    ctr_d = ctr_q - ONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= MID;
        else     ctr_q <= ctr_d;
    end

    AST_CTR_OFF_RAILS: assert property (@(posedge clk) disable iff (rst)
        (ctr_q != '0) && (ctr_q != TOP)); // R6

    AST_RELOAD_MID: assert property (@(posedge clk) disable iff (rst)
        (resize != RESIZE_NONE) |=> (ctr_q == MID)); // R6

    AST_HOLD_KEEPS_CTR: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD) |=> $stable(ctr_q)); // R2
endmodule

// File: rtl/stp_size_reg.sv
module stp_size_reg
    import stp_pkg::*;
#(
    parameter int SIZE_W    = 16,
    parameter int MIN_LOG2  = 4,
    parameter int MAX_LOG2  = 12,
    parameter int INIT_LOG2 = 8,
    localparam int EXP_W    = $clog2(SIZE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  resize_e           resize,
    output logic [SIZE_W-1:0] size_o
);
    localparam logic [EXP_W-1:0] E_MIN  = EXP_W'(MIN_LOG2);
    localparam logic [EXP_W-1:0] E_MAX  = EXP_W'(MAX_LOG2);
    localparam logic [EXP_W-1:0] E_INIT = EXP_W'(INIT_LOG2);
    localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(1);

    logic [EXP_W-1:0] exp_q, exp_d;

    always_comb begin
        exp_d = exp_q;
        unique case (resize)
            RESIZE_GROW:   if (exp_q < E_MAX) exp_d = exp_q + E_ONE;
            RESIZE_SHRINK: if (exp_q > E_MIN) exp_d = exp_q - E_ONE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) exp_q <= E_INIT;
        else     exp_q <= exp_d;
    end

    assign size_o = SIZE_W'(1) << exp_q;

    AST_EXP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (exp_q >= E_MIN) && (exp_q <= E_MAX)); // R9

    AST_GROW_DOUBLES: assert property (@(posedge clk) disable iff (rst)
        (resize == RESIZE_GROW) && (exp_q < E_MAX) |=> exp_q == $past(exp_q) + E_ONE); // R4

    AST_SHRINK_HALVES: assert property (@(posedge clk) disable iff (rst)
        (resize == RESIZE_SHRINK) && (exp_q > E_MIN) |=> exp_q == $past(exp_q) - E_ONE); // R3

    AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (rst)
        (resize == RESIZE_GROW) && (exp_q == E_MAX) |=> $stable(exp_q)); // R7

    AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (resize == RESIZE_SHRINK) && (exp_q == E_MIN) |=> $stable(exp_q)); // R8
endmodule

// File: rtl/stratum_size_predictor.sv
module stratum_size_predictor
    import stp_pkg::*;
#(
    parameter int SIZE_W    = 16,
    parameter int MIN_LOG2  = 4,
    parameter int MAX_LOG2  = 12,
    parameter int INIT_LOG2 = 8,
    parameter int CONF_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              end_pulse,
    input  logic              sync_end,
    input  logic              ovf_end,
    input  logic              thr_end,
    output logic [SIZE_W-1:0] size_o
);
    step_e   step;
    resize_e resize;

    stp_cause_decode u_decode (
        .end_pulse (end_pulse),
        .sync_end  (sync_end),
        .ovf_end   (ovf_end),
        .thr_end   (thr_end),
        .step      (step)
    );

    stp_conf_ctr #(.CONF_W(CONF_W)) u_conf (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .resize (resize)
    );

    stp_size_reg #(
        .SIZE_W    (SIZE_W),
        .MIN_LOG2  (MIN_LOG2),
        .MAX_LOG2  (MAX_LOG2),
        .INIT_LOG2 (INIT_LOG2)
    ) u_size (
        .clk    (clk),
        .rst    (rst),
        .resize (resize),
        .size_o (size_o)
    );

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !end_pulse |=> $stable(size_o)); // R2

    AST_EARLY_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        end_pulse && (sync_end || ovf_end) |=> size_o <= $past(size_o)); // R3

    AST_LATE_NO_SHRINK: assert property (@(posedge clk) disable iff (rst)
        end_pulse && !sync_end && !ovf_end |=> size_o >= $past(size_o)); // R4

    AST_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(size_o) == 1); // R9

    AST_FACTOR_TWO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (size_o == $past(size_o)) || (size_o == ($past(size_o) << 1))
                 || (size_o == ($past(size_o) >> 1))); // R9
endmodule

// File: tb/tb_stratum_size_predictor.sv
`timescale 1ns/1ps
module tb_stratum_size_predictor;

    localparam int SIZE_W = 16;

    typedef struct packed {
        logic        e;
        logic        s;
        logic        o;
        logic        t;
        logic [3:0]  req;
        logic [15:0] size;
    } vec_t;

    // Walked in order from reset (size 256, counter at rest 1)
    localparam vec_t VEC [12] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 16'd256},  // R4 up, counter 2
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 16'd512},  // R4 second up doubles
        '{1'b0, 1'b1, 1'b1, 1'b0, 4'd2, 16'd512},  // R2 flags without strobe
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 16'd256},  // R3 sync halves
        '{1'b1, 1'b0, 1'b1, 1'b0, 4'd3, 16'd128},  // R3 overflow halves
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd4, 16'd128},  // R4 no flag counts up
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'd6, 16'd128},  // R6 up then down, no change
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'd5, 16'd64},   // R5 sync beats threshold
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 16'd64},   // R4 up
        '{1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 16'd64},   // R5 overflow beats threshold
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 16'd64},   // R4 up
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 16'd128}   // R4 doubles
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              end_pulse = 1'b0;
    logic              sync_end = 1'b0;
    logic              ovf_end = 1'b0;
    logic              thr_end = 1'b0;
    logic [SIZE_W-1:0] size_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stratum_size_predictor dut (
        .clk       (clk),
        .rst       (rst),
        .end_pulse (end_pulse),
        .sync_end  (sync_end),
        .ovf_end   (ovf_end),
        .thr_end   (thr_end),
        .size_o    (size_o)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic e, input logic s, input logic o, input logic t);
        @(negedge clk);
        end_pulse = e; sync_end = s; ovf_end = o; thr_end = t;
        @(negedge clk);
        end_pulse = 1'b0; sync_end = 1'b0; ovf_end = 1'b0; thr_end = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", int'(size_o), 256);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'(size_o), 256);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset();

        foreach (VEC[i]) begin
            apply(VEC[i].e, VEC[i].s, VEC[i].o, VEC[i].t);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), int'(size_o), int'(VEC[i].size));
            check($sformatf("R9 vector %0d single bit", i), $countones(size_o), 1);
        end

        // R8: drive down to the floor and past it
        do_reset();
        apply(1, 0, 1, 0); check("R8 step 1", int'(size_o), 128);
        apply(1, 0, 1, 0); check("R8 step 2", int'(size_o), 64);
        apply(1, 1, 0, 0); check("R8 step 3", int'(size_o), 32);
        apply(1, 0, 1, 0); check("R8 step 4", int'(size_o), 16);
        apply(1, 1, 0, 0); check("R8 clamp at floor", int'(size_o), 16);
        apply(1, 0, 0, 1); check("R8 reload, first up", int'(size_o), 16);
        apply(1, 0, 0, 1); check("R8 reload, second up doubles", int'(size_o), 32);

        // R7: drive up to the ceiling and past it
        do_reset();
        for (int k = 0; k < 8; k++) apply(1, 0, 0, 1);
        check("R7 reached ceiling", int'(size_o), 4096);
        apply(1, 0, 0, 1);
        check("R7 one up at ceiling", int'(size_o), 4096);
        apply(1, 0, 0, 1);
        check("R7 clamp at ceiling", int'(size_o), 4096);
        apply(1, 1, 0, 0);
        check("R7 reload then early end halves", int'(size_o), 2048);

        // R2: idle cycles with flags but no strobe
        apply(0, 1, 1, 1);
        apply(0, 0, 0, 1);
        check("R2 flags ignored", int'(size_o), 2048);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule